// File: doc/BRIEF.md
# Pin-strapped I2C target interface

This block is the target (slave) side of a two-wire serial bus compatible with I2C and SMBus. It runs on a fast system clock and oversamples the clock and data lines. Each line passes through a synchronizer and a short majority filter. Start and stop conditions are then found from the filtered levels. The block never generates the clock, a start or a stop. It acts on the bus only by enabling a pull-down on the data line.

The upper five bits of the 7-bit target address are fixed. The lower two bits come from one strap input. That input may be wired low, wired high, wired to the data line or wired to the clock line. The block classifies the wiring again at every start condition, so the address can change between transactions.

After an address match, write bytes come out as a one-cycle strobe with the byte. For reads, the block samples a byte supplied by the register side and reports each sample with a one-cycle strobe. A count of system cycles with no clock edge during a transfer returns the interface to idle, so a stalled master cannot hold the bus.

Top module: `i2c_strap_slave`

## Requirements
- R1: A stop (data rising while the clock is high) returns the block to idle with the data line released. A start (data falling while the clock is high) begins a new address phase from any state, including in the middle of a transaction (repeated start).
- R2: When the received address matches, the block pulls the data line low while the clock is high on the ninth pulse. It releases the line at the clock fall that ends that pulse.
- R3: A byte whose upper seven bits do not match is not acknowledged. No write strobe or read strobe is produced until the next start.
- R4: The address is binary 10000 followed by a 2-bit code taken from the strap wiring: strap low gives 00, strap high gives 01, strap on the data line gives 10, strap on the clock line gives 11. The code is classified again at every start condition.
- R5: Write bytes are sampled MSB first on clock rises. Each complete byte produces a one-cycle write strobe with the byte value, and each byte is acknowledged.
- R6: In a read, a byte from the register side is sampled, with a one-cycle take strobe, at the clock fall that ends the address acknowledge or a master acknowledge. The byte is sent MSB first, and a 0 bit is sent by pulling the line low.
- R7: A not-acknowledge from the master ends the read. The block then releases the data line and takes no more bytes until a stop or start.
- R8: While a transaction is open, TIMEOUT_CYCLES system clocks without a clock edge return the block to idle with the data line released. Bus activity after that is ignored until a new start.
- R9: A data-line pulse that lasts one system clock is filtered out. It is taken neither as a start or stop nor as a data change.
- R10: The pull-down enable is asserted only while the filtered clock line is low.
- R11: After reset the pull-down enable, the write strobe and the take strobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Address strap pin level |
| rd_data_i | input | 8 | Next byte to send in a read |
| sda_oe_o | output | 1 | Pull-down enable for the data line |
| wr_valid_o | output | 1 | One-cycle strobe: a write byte was received |
| wr_data_o | output | 8 | Received write byte |
| rd_take_o | output | 1 | One-cycle strobe: rd_data_i was sampled |

## Verification
The bench runs all four strap wirings, each with an address that matches. A classifier that muddled the data-tied and clock-tied cases, or that latched the strap once at reset, would fail to acknowledge one of them. A repeated start switches a write into a read, and the read ends with a not-acknowledge. A design that ignored the repeated start would take the address byte as data. A design that kept driving after the not-acknowledge would pull the line low on the following clock or take a third byte. A one-clock data glitch while the clock is high would corrupt the byte or abort the transfer in a design without the filter. A stall longer than the timeout followed by more clocks checks that the stale transfer gets no acknowledge and produces no write strobe.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_ADDR_ACK= 3'd2,
    ST_WR      = 3'd3,
    ST_WR_ACK  = 3'd4,
    ST_RD      = 3'd5,
    ST_RD_ACK  = 3'd6,
    ST_WAIT    = 3'd7
  } i2cs_state_e;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_DATA = 2'b10,
    STRAP_CLK  = 2'b11
  } strap_code_e;

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter logic        RST_VAL     = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  localparam int unsigned SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q, sync_d;
  logic [1:0]    win_q, win_d;
  logic          out_q, out_d;
  logic          cur;

  assign cur = sync_q[SW-1];

  always_comb begin
    sync_d = {sync_q[SW-2:0], d_i};
    win_d  = {win_q[0], cur};
    out_d  = (cur & win_q[0]) | (cur & win_q[1]) | (win_q[0] & win_q[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SW{RST_VAL}};
      win_q  <= {2{RST_VAL}};
      out_q  <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      win_q  <= win_d;
      out_q  <= out_d;
    end
  end

  assign q_o = out_q;

  AST_FLT_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (win_q[0] == out_q || win_q[1] == out_q)); // R9

endmodule

// File: rtl/i2cs_strap_decode.sv
module i2cs_strap_decode
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_i,
  input  logic       start_i,
  input  logic       scl_fall_i,
  output logic [1:0] code_o
);

  logic        prev_q;
  logic        pend_q, pend_d;
  strap_code_e code_q, code_d;

  always_comb begin
    pend_d = pend_q;
    code_d = code_q;
    if (start_i) begin
      if (!strap_i && prev_q) begin
        code_d = STRAP_DATA;
        pend_d = 1'b0;
      end else if (!strap_i) begin
        code_d = STRAP_LOW;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
      end
    end else if (pend_q && scl_fall_i) begin
      code_d = strap_i ? STRAP_HIGH : STRAP_CLK;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      code_q <= STRAP_LOW;
    end else begin
      prev_q <= strap_i;
      pend_q <= pend_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !pend_q) |=> $stable(code_q)); // R4

endmodule

// File: rtl/i2cs_bus_timeout.sv
module i2cs_bus_timeout #(
  parameter int unsigned LIMIT = 2_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic kick_i,
  output logic expire_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  assign hit = active_i && !kick_i && (cnt_q == LAST);

  always_comb begin
    if (!active_i || kick_i || hit) cnt_d = '0;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = hit;

  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !expire_o); // R8

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter logic [4:0]  ADDR_HI        = 5'b10000,
  parameter int unsigned TIMEOUT_CYCLES = 2_800_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       strap_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_data_o,
  output logic       rd_take_o
);

  localparam int unsigned NLINES = 3;
  localparam int unsigned BW     = 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  // line conditioning
  logic [NLINES-1:0] raw, filt;
  assign raw = {strap_i, sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_flt
    i2cs_glitch_filter #(.RST_VAL(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_flt (
      .clk   (clk),
      .rst_n (rst_l),
      .d_i   (raw[g]),
      .q_o   (filt[g])
    );
  end

  logic scl_f, sda_f, strap_f;
  logic scl_q, sda_q;
  assign scl_f   = filt[0];
  assign sda_f   = filt[1];
  assign strap_f = filt[2];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic bus_start, bus_stop, scl_rise, scl_fall;
  assign bus_start = scl_f && scl_q && sda_q && !sda_f;
  assign bus_stop  = scl_f && scl_q && !sda_q && sda_f;
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;

  // address strap classification
  logic [1:0] strap_code;
  i2cs_strap_decode u_strap (
    .clk        (clk),
    .rst_n      (rst_l),
    .strap_i    (strap_f),
    .start_i    (bus_start),
    .scl_fall_i (scl_fall),
    .code_o     (strap_code)
  );

  // inactivity timeout
  i2cs_state_e state_q, state_d;
  logic tmo;
  i2cs_bus_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_l),
    .active_i (state_q != ST_IDLE),
    .kick_i   (scl_rise || scl_fall),
    .expire_o (tmo)
  );

  // protocol engine
  logic [3:0]    cnt_q, cnt_d;
  logic [BW-1:0] sh_q, sh_d;
  logic [BW-1:0] byte_in;
  logic          oe_q, oe_d;
  logic          rw_q, rw_d;
  logic          wv_q, wv_d;
  logic [BW-1:0] wd_q, wd_d;
  logic          tk_q, tk_d;
  logic          addr_hit;

  assign byte_in  = {sh_q[BW-2:0], sda_f};
  assign addr_hit = (byte_in[BW-1:1] == {ADDR_HI, strap_code});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    wd_d    = wd_q;
    wv_d    = 1'b0;
    tk_d    = 1'b0;
    if (bus_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (bus_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (tmo) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_d = byte_in;
          if (cnt_q == 4'd7) begin
            cnt_d   = '0;
            rw_d    = byte_in[0];
            state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (!oe_q) begin
            oe_d = 1'b1;
          end else if (rw_q) begin
            oe_d    = ~rd_data_i[BW-1];
            sh_d    = {rd_data_i[BW-2:0], 1'b0};
            tk_d    = 1'b1;
            cnt_d   = '0;
            state_d = ST_RD;
          end else begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WR;
          end
        end
        ST_WR: if (scl_rise) begin
          sh_d = byte_in;
          if (cnt_q == 4'd7) begin
            wv_d    = 1'b1;
            wd_d    = byte_in;
            cnt_d   = '0;
            state_d = ST_WR_ACK;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WR_ACK: if (scl_fall) begin
          if (!oe_q) begin
            oe_d = 1'b1;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_RD_ACK;
            end else begin
              oe_d = ~sh_q[BW-1];
              sh_d = {sh_q[BW-2:0], 1'b0};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (!sda_f) cnt_d = 4'd1;
            else        state_d = ST_WAIT;
          end else if (scl_fall && cnt_q == 4'd1) begin
            oe_d    = ~rd_data_i[BW-1];
            sh_d    = {rd_data_i[BW-2:0], 1'b0};
            tk_d    = 1'b1;
            cnt_d   = '0;
            state_d = ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      wv_q    <= 1'b0;
      wd_q    <= '0;
      tk_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      wv_q    <= wv_d;
      wd_q    <= wd_d;
      tk_q    <= tk_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = wv_q;
  assign wr_data_o  = wd_q;
  assign rd_take_o  = tk_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_IDLE) |-> !oe_q); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_l)
    bus_stop |=> (state_q == ST_IDLE)); // R1
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(oe_q) |-> !scl_f); // R10
  AST_WR_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_l)
    wv_q |-> (state_q == ST_WR_ACK)); // R5
  AST_TAKE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_l)
    tk_q |-> (state_q == ST_RD && !scl_f)); // R6
  AST_NACK_WAIT: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_RD_ACK && scl_rise && sda_f && !bus_start && !bus_stop && !tmo)
    |=> (state_q == ST_WAIT && !oe_q)); // R7
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_l)
    (tmo && !bus_start && !bus_stop) |=> (state_q == ST_IDLE && !oe_q)); // R8
  AST_MISS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_WAIT) |-> (!wv_q && !tk_q)); // R3

endmodule

// File: tb/i2c_strap_slave_bench.sv
module i2c_strap_slave_bench;

  localparam int Q   = 16;
  localparam int TMO = 400;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  int   strap_mode;
  logic strap_w;
  logic sda_oe, wr_valid, rd_take;
  logic [7:0] wr_data, rd_data;
  wire  sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  always_comb begin
    case (strap_mode)
      0:       strap_w = 1'b0;
      1:       strap_w = 1'b1;
      2:       strap_w = sda_bus;
      default: strap_w = scl_m;
    endcase
  end

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  int rd_idx  = 0;
  int r10_bad = 0;
  logic [7:0] wr_log [0:63];
  logic oe_prev = 1'b0;

  function automatic logic [7:0] rd_pat(input int i);
    return 8'hA5 ^ 8'(i * 8'h37);
  endfunction
  assign rd_data = rd_pat(rd_idx);

  i2c_strap_slave #(.TIMEOUT_CYCLES(TMO)) u_i2c_strap_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap_w),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe), .wr_valid_o(wr_valid),
    .wr_data_o(wr_data), .rd_take_o(rd_take)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_log[wr_cnt[5:0]] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_take) rd_idx <= rd_idx + 1;
  end

  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) r10_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; w(Q);
    scl_m = 1'b1; w(Q);
    if (glitch) begin
      sda_m = ~b; w(1);
      sda_m = b;  w(Q-1);
    end else begin
      w(Q);
    end
    scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    b = sda_bus; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gbit, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(v[i], (i == gbit));
    recv_bit(nack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(nack, 1'b0);
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", int'(sda_oe), 0);
    chk("R11 wr_valid after reset", int'(wr_valid), 0);
    chk("R11 rd_take after reset", int'(rd_take), 0);
  endtask

  // strap code: 0 low ->00, 1 high ->01, 2 data ->10, 3 clock ->11
  task automatic t_strap(input int mode, input logic [7:0] data);
    logic nk;
    int base;
    strap_mode = mode; w(Q);
    base = wr_cnt;
    bus_start();
    send_byte({5'b10000, 2'(mode), 1'b0}, -1, nk);
    chk($sformatf("R4/R2 ack for strap mode %0d", mode), int'(nk), 0);
    w(Q);
    chk("R2 released after ack", int'(sda_oe), 0);
    send_byte(data, -1, nk);
    chk("R5 data ack", int'(nk), 0);
    chk("R5 one write strobe", wr_cnt - base, 1);
    chk("R5 write byte", int'(wr_log[base[5:0]]), int'(data));
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic nk;
    int base;
    strap_mode = 0; w(Q);
    base = wr_cnt;
    bus_start();
    send_byte(8'b1000_0100, -1, nk);
    chk("R3 no ack on other address", int'(nk), 1);
    send_byte(8'h5A, -1, nk);
    chk("R3 data not acked", int'(nk), 1);
    chk("R3 no write strobe", wr_cnt - base, 0);
    bus_stop();
  endtask

  task automatic t_multi_write();
    logic nk;
    int base;
    logic [7:0] v [3];
    v[0] = 8'h00; v[1] = 8'hFF; v[2] = 8'h3C;
    strap_mode = 1; w(Q);
    base = wr_cnt;
    bus_start();
    send_byte(8'b1000_0010, -1, nk);
    chk("R2 ack write address", int'(nk), 0);
    for (int i = 0; i < 3; i++) begin
      send_byte(v[i], -1, nk);
      chk("R5 multi byte ack", int'(nk), 0);
    end
    chk("R5 three strobes", wr_cnt - base, 3);
    for (int i = 0; i < 3; i++)
      chk("R5 multi byte value", int'(wr_log[6'(base + i)]), int'(v[i]));
    bus_stop();
  endtask

  task automatic t_restart_read();
    logic nk, b;
    logic [7:0] got;
    int base, rbase;
    strap_mode = 3; w(Q);
    base = wr_cnt;
    rbase = rd_idx;
    bus_start();
    send_byte(8'b1000_0110, -1, nk);
    send_byte(8'h11, -1, nk);
    chk("R1 byte before repeated start", int'(wr_log[base[5:0]]), 8'h11);
    bus_start();
    send_byte(8'b1000_0111, -1, nk);
    chk("R1 ack read address after repeated start", int'(nk), 0);
    chk("R1 address byte not taken as data", wr_cnt - base, 1);
    recv_byte(1'b0, got);
    chk("R6 first read byte", int'(got), int'(rd_pat(rbase)));
    recv_byte(1'b1, got);
    chk("R6 second read byte", int'(got), int'(rd_pat(rbase + 1)));
    w(Q);
    chk("R7 released after nack", int'(sda_oe), 0);
    recv_bit(b);
    chk("R7 line high after nack", int'(b), 1);
    chk("R7 two takes only", rd_idx - rbase, 2);
    bus_stop();
  endtask

  task automatic t_timeout();
    logic nk;
    int base;
    strap_mode = 0; w(Q);
    base = wr_cnt;
    bus_start();
    send_byte(8'b1000_0000, -1, nk);
    chk("R8 ack before stall", int'(nk), 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    w(2*TMO);
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
    recv_bit(nk);
    chk("R8 no ack after timeout", int'(nk), 1);
    chk("R8 no strobe after timeout", wr_cnt - base, 0);
    bus_stop();
    bus_start();
    send_byte(8'b1000_0000, -1, nk);
    chk("R8 fresh transfer acked", int'(nk), 0);
    bus_stop();
  endtask

  task automatic t_glitch();
    logic nk;
    int base;
    strap_mode = 1; w(Q);
    base = wr_cnt;
    bus_start();
    send_byte(8'b1000_0010, -1, nk);
    send_byte(8'hFF, 3, nk);
    chk("R9 ack with low glitch", int'(nk), 0);
    send_byte(8'h00, 4, nk);
    chk("R9 ack with high glitch", int'(nk), 0);
    chk("R9 strobes", wr_cnt - base, 2);
    chk("R9 byte with low glitch", int'(wr_log[base[5:0]]), 8'hFF);
    chk("R9 byte with high glitch", int'(wr_log[6'(base + 1)]), 8'h00);
    bus_stop();
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap_mode = 0;
    w(5);
    rst_n = 1'b1;
    w(10);
    t_reset();
    t_strap(0, 8'h81);
    t_strap(1, 8'h42);
    t_strap(2, 8'h24);
    t_strap(3, 8'h18);
    t_mismatch();
    t_multi_write();
    t_restart_read();
    t_timeout();
    t_glitch();
    chk("R10 pull-down only with clock low", r10_bad, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule